// File: doc/BRIEF.md
# Bit-serial Modbus RTU CRC-16 engine

This block computes the 16-bit cyclic redundancy check used in Modbus RTU frames. Frame bytes enter on a valid/ready handshake. A start-of-frame pulse reloads the check register with all ones. Each accepted byte is folded into the low half of the register. The register is then advanced one bit per clock for eight clocks, using the reflected, right-shifting form with polynomial A001h. The upstream source raises a last-byte flag with the final byte of a frame. When that byte has been shifted through, the engine pulses a done strobe and presents the result as two bytes in transmit order. The low byte goes on the wire first, the high byte second.

For received frames, the same engine runs in check mode. The payload and then the two received check bytes (low first, then high) are fed as one frame. An intact frame leaves the register at zero, and the engine reports pass or fail together with the done strobe. Serial line timing, detection of inter-frame gaps and parsing of frame fields belong to other blocks.

Top module: `crc16_serial_engine`

## Requirements
- R1: After reset, `byte_ready_o` is 1 and `crc_done_o`, `chk_pass_o` and `chk_fail_o` are 0.
- R2: A cycle with `sof_i` high reloads the register with FFFFh, so every frame's result depends only on that frame's bytes, whatever the previous frame left behind.
- R3: Per byte, the byte is XORed into register bits 7:0. Then eight steps each examine bit 0, shift the register right by one with a 0 entering bit 15, and XOR A001h into the shifted value when the examined bit was 1. The nine ASCII bytes "123456789" give 4B37h.
- R4: A byte is accepted in a cycle where `byte_valid_i` and `byte_ready_o` are both 1. `byte_ready_o` is then 0 for exactly the next eight cycles (the shift steps) and returns to 1 in the ninth.
- R5: After a byte accepted with `byte_last_i` = 1, `crc_done_o` is 1 for exactly one cycle. That cycle is the one in which `byte_ready_o` returns to 1, and it is the cycle after the eighth shift.
- R6: During and after `crc_done_o`, `crc_lo_o` carries register bits 7:0, which are sent first. `crc_hi_o` carries bits 15:8, which are sent second. For "123456789" these are 37h and 4Bh.
- R7: When `chk_mode_i` = 1 at the start-of-frame pulse, the frame is run in check mode, and both flags appear only in the `crc_done_o` cycle. If the final register is 0000h, `chk_pass_o` = 1 and `chk_fail_o` = 0. If it is not zero, the values are reversed.
- R8: `sof_i` while a byte is being shifted discards that partial byte, reloads FFFFh and brings `byte_ready_o` back to 1 in the next cycle.
- R9: `byte_valid_i` and `byte_data_i` have no effect while `byte_ready_o` is 0.
- R10: A byte presented with `byte_valid_i` = 1 in the same cycle as `sof_i` is accepted as the first byte of the new frame.
- R11: `crc_lo_o` and `crc_hi_o` hold the last result until the next `crc_done_o`, including while a new frame is being shifted.
- R12: When `chk_mode_i` = 0 at the start-of-frame pulse, `chk_pass_o` and `chk_fail_o` stay 0 for that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sof_i | input | 1 | Start-of-frame pulse; reloads FFFFh and samples the mode |
| chk_mode_i | input | 1 | 1 = receive check mode, 0 = generate mode; sampled with `sof_i` |
| byte_valid_i | input | 1 | Byte on `byte_data_i` is offered |
| byte_data_i | input | 8 | Frame byte |
| byte_last_i | input | 1 | Offered byte is the last of the frame |
| byte_ready_o | output | 1 | Engine can accept a byte this cycle |
| crc_done_o | output | 1 | One-cycle strobe: frame result available |
| crc_lo_o | output | 8 | Result low byte (sent first) |
| crc_hi_o | output | 8 | Result high byte (sent second) |
| chk_pass_o | output | 1 | Check mode: received frame intact, with done |
| chk_fail_o | output | 1 | Check mode: received frame corrupted, with done |

## Verification
The assertions assume that `sof_i` arrives as an isolated pulse and is never held through a frame. They also assume that `chk_mode_i` matters only in start-of-frame cycles and that a frame ends only with a byte flagged last. The bench meets these assumptions by driving every input at falling edges from one task per scenario. It raises `sof_i` for exactly one cycle, changes `chk_mode_i` only with it, and flags only the final byte of each frame. When it offers data while `byte_ready_o` is low, that data is deliberate junk used to show that it is ignored.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE  = 1'b0,
      SEQ_SHIFT = 1'b1
   } seq_state_e;

endpackage

// File: rtl/crc16_bit_step.sv
module crc16_bit_step #(
   parameter int unsigned        CRC_W = 16,
   parameter logic [CRC_W-1:0]   POLY  = 16'hA001
) (
   input  logic [CRC_W-1:0] crc_i,
   output logic [CRC_W-1:0] crc_o
);

   if (CRC_W < 2) begin : g_bad_width
      $error("crc16_bit_step: CRC_W must be at least 2");
   end

   logic             out_bit;
   logic [CRC_W-1:0] shifted;

   always_comb begin
      out_bit = crc_i[0];
      shifted = {1'b0, crc_i[CRC_W-1:1]};
      crc_o   = out_bit ? (shifted ^ POLY) : shifted;
   end

endmodule

// File: rtl/crc16_bit_sequencer.sv
module crc16_bit_sequencer
   import crc16_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sof_i,
   input  logic valid_i,
   input  logic last_i,
   output logic ready_o,
   output logic accept_o,
   output logic shift_o,
   output logic frame_end_o
);

   localparam int unsigned    CNT_W     = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("crc16_bit_sequencer: DATA_W must be at least 2");
   end

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_q;
   logic             final_step;

   always_comb begin
      ready_o     = (state_q == SEQ_IDLE);
      accept_o    = valid_i & ready_o;
      shift_o     = (state_q == SEQ_SHIFT) & ~sof_i;
      final_step  = shift_o & (cnt_q == LAST_STEP);
      frame_end_o = final_step & last_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         last_q  <= 1'b0;
      end else if (accept_o) begin
         state_q <= SEQ_SHIFT;
         cnt_q   <= '0;
         last_q  <= last_i;
      end else if (sof_i) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         last_q  <= 1'b0;
      end else if (shift_o) begin
         cnt_q <= cnt_q + 1'b1;
         if (final_step) begin
            state_q <= SEQ_IDLE;
         end
      end
   end

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> !ready_o); // R4

   AST_SHIFT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_o && (cnt_q != LAST_STEP)) |=> !ready_o); // R4

   AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      final_step |=> ready_o); // R4

   AST_SOF_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_i && !accept_o) |=> ready_o); // R8

endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath #(
   parameter int unsigned      DATA_W = 8,
   parameter int unsigned      CRC_W  = 16,
   parameter logic [CRC_W-1:0] POLY   = 16'hA001,
   parameter logic [CRC_W-1:0] INIT   = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              accept_i,
   input  logic              shift_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  step_o
);

   localparam int unsigned PAD_W = CRC_W - DATA_W;

   if (CRC_W <= DATA_W) begin : g_bad_width
      $error("crc16_datapath: CRC_W must exceed DATA_W");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] step_w;
   logic [CRC_W-1:0] data_ext;

   assign data_ext = {{PAD_W{1'b0}}, data_i};

   crc16_bit_step #(
      .CRC_W (CRC_W),
      .POLY  (POLY)
   ) u_step (
      .crc_i (crc_q),
      .crc_o (step_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= INIT;
      end else if (sof_i) begin
         crc_q <= accept_i ? (INIT ^ data_ext) : INIT;
      end else if (accept_i) begin
         crc_q <= crc_q ^ data_ext;
      end else if (shift_i) begin
         crc_q <= step_w;
      end
   end

   assign step_o = step_w;

   AST_SOF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_i && !accept_i) |=> (crc_q == INIT)); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof_i && !accept_i && !shift_i) |=> $stable(crc_q)); // R9

endmodule

// File: rtl/crc16_result_stage.sv
module crc16_result_stage #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CRC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              chk_mode_i,
   input  logic              frame_end_i,
   input  logic [CRC_W-1:0]  step_i,
   output logic              done_o,
   output logic [DATA_W-1:0] lo_o,
   output logic [DATA_W-1:0] hi_o,
   output logic              pass_o,
   output logic              fail_o
);

   localparam int unsigned NUM_LANES = CRC_W / DATA_W;

   if (NUM_LANES * DATA_W != CRC_W) begin : g_bad_split
      $error("crc16_result_stage: CRC_W must be a multiple of DATA_W");
   end

   logic              mode_q;
   logic              done_q;
   logic              pass_q;
   logic              fail_q;
   logic [CRC_W-1:0]  snap_q;
   logic [DATA_W-1:0] lane_w [NUM_LANES];
   logic              zero_w;

   assign zero_w = (step_i == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         done_q <= 1'b0;
         pass_q <= 1'b0;
         fail_q <= 1'b0;
         snap_q <= '0;
      end else begin
         if (sof_i) begin
            mode_q <= chk_mode_i;
         end
         done_q <= frame_end_i;
         pass_q <= frame_end_i & mode_q & zero_w;
         fail_q <= frame_end_i & mode_q & ~zero_w;
         if (frame_end_i) begin
            snap_q <= step_i;
         end
      end
   end

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      assign lane_w[g] = snap_q[g*DATA_W +: DATA_W];
   end

   assign lo_o   = lane_w[0];
   assign hi_o   = lane_w[NUM_LANES-1];
   assign done_o = done_q;
   assign pass_o = pass_q;
   assign fail_o = fail_q;

   AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o)); // R7

   AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_o || fail_o) |-> done_o); // R7

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(lo_o) && $stable(hi_o))); // R11

   AST_GEN_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !$past(mode_q)) |-> (!pass_o && !fail_o)); // R12

endmodule

// File: rtl/crc16_serial_engine.sv
module crc16_serial_engine #(
   parameter int unsigned      DATA_W = 8,
   parameter int unsigned      CRC_W  = 16,
   parameter logic [CRC_W-1:0] POLY   = 16'hA001,
   parameter logic [CRC_W-1:0] INIT   = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              chk_mode_i,
   input  logic              byte_valid_i,
   input  logic [DATA_W-1:0] byte_data_i,
   input  logic              byte_last_i,
   output logic              byte_ready_o,
   output logic              crc_done_o,
   output logic [DATA_W-1:0] crc_lo_o,
   output logic [DATA_W-1:0] crc_hi_o,
   output logic              chk_pass_o,
   output logic              chk_fail_o
);

   if (CRC_W != 2 * DATA_W) begin : g_bad_lanes
      $error("crc16_serial_engine: CRC_W must be twice DATA_W");
   end
   if (POLY[CRC_W-1] != 1'b1) begin : g_bad_poly
      $error("crc16_serial_engine: reflected POLY must have its top bit set");
   end

   logic accept_w;
   logic shift_w;
   logic frame_end_w;
   logic [CRC_W-1:0] step_w;

   crc16_bit_sequencer #(
      .DATA_W (DATA_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .sof_i       (sof_i),
      .valid_i     (byte_valid_i),
      .last_i      (byte_last_i),
      .ready_o     (byte_ready_o),
      .accept_o    (accept_w),
      .shift_o     (shift_w),
      .frame_end_o (frame_end_w)
   );

   crc16_datapath #(
      .DATA_W (DATA_W),
      .CRC_W  (CRC_W),
      .POLY   (POLY),
      .INIT   (INIT)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof_i    (sof_i),
      .accept_i (accept_w),
      .shift_i  (shift_w),
      .data_i   (byte_data_i),
      .step_o   (step_w)
   );

   crc16_result_stage #(
      .DATA_W (DATA_W),
      .CRC_W  (CRC_W)
   ) u_res (
      .clk         (clk),
      .rst_n       (rst_n),
      .sof_i       (sof_i),
      .chk_mode_i  (chk_mode_i),
      .frame_end_i (frame_end_w),
      .step_i      (step_w),
      .done_o      (crc_done_o),
      .lo_o        (crc_lo_o),
      .hi_o        (crc_hi_o),
      .pass_o      (chk_pass_o),
      .fail_o      (chk_fail_o)
   );

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done_o |=> !crc_done_o); // R5

   AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done_o |-> byte_ready_o); // R5

endmodule

// File: tb/test_crc16_serial_engine.sv
module test_crc16_serial_engine;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sof = 1'b0;
   logic       chk_mode = 1'b0;
   logic       vld = 1'b0;
   logic [7:0] dat = 8'h00;
   logic       lst = 1'b0;
   logic       rdy;
   logic       done;
   logic [7:0] lo;
   logic [7:0] hi;
   logic       pass;
   logic       fail;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   logic [7:0] frm [0:15];

   always #(CLK_PERIOD/2) clk = ~clk;

   crc16_serial_engine i_crc16_serial_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof_i        (sof),
      .chk_mode_i   (chk_mode),
      .byte_valid_i (vld),
      .byte_data_i  (dat),
      .byte_last_i  (lst),
      .byte_ready_o (rdy),
      .crc_done_o   (done),
      .crc_lo_o     (lo),
      .crc_hi_o     (hi),
      .chk_pass_o   (pass),
      .chk_fail_o   (fail)
   );

   function automatic logic [15:0] model(input int n);
      logic [15:0] c;
      c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {8'h00, frm[i]};
         for (int b = 0; b < 8; b++) begin
            if (c[0]) c = (c >> 1) ^ 16'hA001;
            else      c = c >> 1;
         end
      end
      return c;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load_digits();
      for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
   endtask

   // all tasks start and end at a falling edge
   task automatic pulse_sof(input logic mode);
      sof = 1'b1;
      chk_mode = mode;
      @(negedge clk);
      sof = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d, input logic last);
      while (!rdy) @(negedge clk);
      vld = 1'b1;
      dat = d;
      lst = last;
      @(negedge clk);
      vld = 1'b0;
      lst = 1'b0;
   endtask

   // sends frm[0..n-1], ends in the cycle where done is expected
   task automatic run_frame(input int n, input logic mode);
      pulse_sof(mode);
      for (int i = 0; i < n; i++) send_byte(frm[i], (i == n-1));
      repeat (7) @(negedge clk);
      chk("R5 done not early", done, 1'b0);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 ready after reset", rdy, 1'b1);
      chk("R1 done after reset", done, 1'b0);
      chk("R1 pass after reset", pass, 1'b0);
      chk("R1 fail after reset", fail, 1'b0);
   endtask

   task automatic t_check_value();
      load_digits();
      run_frame(9, 1'b0);
      chk("R5 done strobe", done, 1'b1);
      chk("R5 ready with done", rdy, 1'b1);
      chk("R3 check value", {hi, lo}, 16'h4B37);
      chk("R6 low byte first", lo, 8'h37);
      chk("R6 high byte second", hi, 8'h4B);
      chk("R12 no pass in gen mode", pass, 1'b0);
      chk("R12 no fail in gen mode", fail, 1'b0);
      @(negedge clk);
      chk("R5 done one cycle", done, 1'b0);
   endtask

   task automatic t_ready_timing();
      int cnt;
      pulse_sof(1'b0);
      vld = 1'b1;
      dat = 8'h31;
      lst = 1'b0;
      @(negedge clk);
      vld = 1'b0;
      cnt = 0;
      while (!rdy && cnt < 20) begin
         cnt++;
         @(negedge clk);
      end
      chk("R4 ready low cycles", cnt, 8);
      chk("R5 no done without last", done, 1'b0);
   endtask

   task automatic t_patterns();
      frm[0] = 8'h00;
      run_frame(1, 1'b0);
      chk("R3 single 00h", {hi, lo}, model(1));
      frm[0] = 8'hFF;
      run_frame(1, 1'b0);
      chk("R3 single FFh", {hi, lo}, model(1));
      frm[0] = 8'h01; frm[1] = 8'h03; frm[2] = 8'h21;
      frm[3] = 8'h02; frm[4] = 8'h00; frm[5] = 8'h02;
      run_frame(6, 1'b0);
      chk("R3 six-byte frame", {hi, lo}, model(6));
      for (int i = 0; i < 12; i++) frm[i] = 8'(i * 37 + 5);
      run_frame(12, 1'b0);
      chk("R3 twelve-byte frame", {hi, lo}, model(12));
   endtask

   task automatic t_reload();
      // previous frame left a nonzero register; a new frame must start from FFFFh
      frm[0] = 8'hA5;
      run_frame(1, 1'b0);
      chk("R2 frame after frame", {hi, lo}, model(1));
   endtask

   task automatic t_rx_check();
      load_digits();
      frm[9]  = 8'h37;
      frm[10] = 8'h4B;
      run_frame(11, 1'b1);
      chk("R7 pass on intact frame", pass, 1'b1);
      chk("R7 no fail on intact frame", fail, 1'b0);
      chk("R7 residue zero", {hi, lo}, 16'h0000);
      @(negedge clk);
      chk("R7 pass only with done", pass, 1'b0);
      frm[10] = 8'h4A;
      run_frame(11, 1'b1);
      chk("R7 fail on corrupt frame", fail, 1'b1);
      chk("R7 no pass on corrupt frame", pass, 1'b0);
   endtask

   task automatic t_abort();
      pulse_sof(1'b0);
      send_byte(8'h55, 1'b0);
      repeat (3) @(negedge clk);
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
      chk("R8 ready after abort", rdy, 1'b1);
      load_digits();
      for (int i = 0; i < 9; i++) send_byte(frm[i], (i == 8));
      repeat (8) @(negedge clk);
      chk("R8 partial byte discarded", {hi, lo}, 16'h4B37);
   endtask

   task automatic t_ignore_busy();
      load_digits();
      pulse_sof(1'b0);
      for (int i = 0; i < 9; i++) begin
         while (!rdy) @(negedge clk);
         vld = 1'b1;
         dat = frm[i];
         lst = (i == 8);
         @(negedge clk);
         dat = 8'hAA;
         lst = 1'b0;
         repeat (8) @(negedge clk);
         vld = 1'b0;
      end
      chk("R9 done with junk offered", done, 1'b1);
      chk("R9 junk while busy ignored", {hi, lo}, 16'h4B37);
   endtask

   task automatic t_sof_with_byte();
      load_digits();
      sof = 1'b1;
      chk_mode = 1'b0;
      vld = 1'b1;
      dat = frm[0];
      lst = 1'b0;
      @(negedge clk);
      sof = 1'b0;
      vld = 1'b0;
      chk("R10 byte taken with sof", rdy, 1'b0);
      for (int i = 1; i < 9; i++) send_byte(frm[i], (i == 8));
      repeat (8) @(negedge clk);
      chk("R10 first byte counted", {hi, lo}, 16'h4B37);
   endtask

   task automatic t_hold();
      load_digits();
      run_frame(9, 1'b0);
      pulse_sof(1'b0);
      send_byte(8'h00, 1'b0);
      send_byte(8'h01, 1'b0);
      while (!rdy) @(negedge clk);
      chk("R11 low byte held", lo, 8'h37);
      chk("R11 high byte held", hi, 8'h4B);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_check_value();
      t_ready_timing();
      t_patterns();
      t_reload();
      t_rx_check();
      t_abort();
      t_ignore_busy();
      t_sof_with_byte();
      t_hold();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule